// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block produces the active-low read and write strobes of a parallel ATA channel for register and data accesses in PIO and multiword-DMA style. Every attached device owns a packed 32-bit timing word. Fields inside the word give, in controller clock cycles, a setup delay that comes before the first cycle of a transfer, a strobe-active time and a strobe-recovery time. Task-file register accesses and data accesses each have their own set of these three fields. The word also holds the UDMA cycle time, the UDMA clock select and four enable bits. This block stores those bits and does not act on them.

A host changes a timing word through an update port with a write mask. The transfer class given with the update picks which bit groups of the word are replaced. All other bits keep their stored value. Any stored word can be read back through a select input.

To start an access, the host raises a request that names a device and gives three tags: task-file or data, read or write, and first or continuing cycle of a burst. The block takes the request only while it is idle. It copies the timing fields that apply at that moment, runs the setup, active and recovery phases, and then gives a single-cycle completion pulse.

Top module: `ata_strobe_timer`

## Requirements
- R1: While reset is held and just after it is released, both strobes are high, req_ready is high, xfer_done is low, and every stored timing word reads as zero.
- R2: For a data access (req_taskfile=0), the strobe stays low for bits [8:4]+1 cycles. After that it stays high for a recovery of bits [3:0]+1 cycles.
- R3: For a task-file access (req_taskfile=1), the active time is bits [17:13]+1 cycles and the recovery is bits [12:9]+1 cycles.
- R4: An access with req_first=1 waits before its strobe falls. The wait is bits [24:22] cycles for a data access and bits [27:25] cycles for a task-file access. A value of zero means no wait. With request accepted at edge E0 and no wait, the strobe is low in the cycle right after E0.
- R5: An access with req_first=0 skips the setup wait, whatever the setup field holds.
- R6: A read (req_write=0) drives only rd_strobe_n low, and a write drives only wr_strobe_n low. The two strobes are never low together, and both are high outside the active phase.
- R7: xfer_done is high for exactly one cycle, the cycle after the last recovery cycle. req_ready is high again in that same cycle.
- R8: req_ready is low from the cycle after a request is accepted until xfer_done. A request presented while req_ready is low is ignored and starts no access.
- R9: An update with upd_class 0 (PIO) replaces only the bits set in 0xCFC3FFFF. Class 1 (multiword DMA) uses the mask 0x31C001FF and class 2 (UDMA) uses 0x303C0000. Class 3 changes nothing. The update applies to device upd_dev, and the new word can be read on tw_rdata at tw_rsel one cycle later.
- R10: The timing fields are captured when a request is accepted, so an update made during an access does not change that access. The next access uses the new word.
- R11: An access uses the timing word of the device named by req_dev.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Apply a masked timing update this cycle |
| upd_dev | input | DEV_W | Device whose word is updated |
| upd_class | input | 2 | Transfer class that selects the mask: 0 PIO, 1 MW-DMA, 2 UDMA, 3 none |
| upd_word | input | 32 | New timing bits |
| tw_rsel | input | DEV_W | Device whose stored word appears on tw_rdata |
| tw_rdata | output | 32 | Stored timing word of device tw_rsel |
| req_valid | input | 1 | Access request |
| req_dev | input | DEV_W | Device addressed by the request |
| req_taskfile | input | 1 | 1 = task-file register access, 0 = data access |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| req_first | input | 1 | 1 = first cycle of a transfer (setup applies) |
| req_ready | output | 1 | Block idle, request can be accepted |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
Most faults in the phase sequencer show up as a wrong strobe width or a wrong completion time. A counter that loads the wrong field, or a phase that takes the wrong branch, changes the count of low strobe cycles or moves the xfer_done cycle within one access. The bench therefore measures, for every access, the first low cycle, the number of low cycles and the index of the done cycle, all counted from the accepting edge. A wrong mask or a wrong device decode in the word store is seen at tw_rdata one cycle after the update. If the fields were not captured at acceptance, the fault shows only in the access that overlaps an update, so a directed test changes the word in the middle of an access.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

  localparam int TW_W    = 32;
  localparam int SETUP_W = 3;
  localparam int ACT_W   = 5;
  localparam int REC_W   = 4;
  localparam int CNT_W   = ACT_W;

  typedef enum logic [1:0] {
    CLS_PIO   = 2'd0,
    CLS_MWDMA = 2'd1,
    CLS_UDMA  = 2'd2,
    CLS_NONE  = 2'd3
  } upd_class_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [SETUP_W-1:0] setup;
    logic [ACT_W-1:0]   act;
    logic [REC_W-1:0]   rec;
  } acc_timing_t;

  // Bit groups that an update of a given transfer class may replace.
  function automatic logic [TW_W-1:0] class_mask(input logic [1:0] cls);
    logic [TW_W-1:0] m;
    case (cls)
      CLS_PIO:   m = 32'hCFC3_FFFF;
      CLS_MWDMA: m = 32'h31C0_01FF;
      CLS_UDMA:  m = 32'h303C_0000;
      default:   m = '0;
    endcase
    return m;
  endfunction

  // Pick the setup/active/recovery fields for a task-file or data access.
  function automatic acc_timing_t pick_timing(input logic [TW_W-1:0] w,
                                              input logic tf);
    acc_timing_t t;
    if (tf) begin
      t.setup = w[27:25];
      t.act   = w[17:13];
      t.rec   = w[12:9];
    end else begin
      t.setup = w[24:22];
      t.act   = w[8:4];
      t.rec   = w[3:0];
    end
    return t;
  endfunction

endpackage

// File: rtl/ata_tword_reg.sv
module ata_tword_reg
  import ata_strobe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [TW_W-1:0] wr_mask,
  input  logic [TW_W-1:0] wr_data,
  output logic [TW_W-1:0] word
);

  logic [TW_W-1:0] word_q;
  logic [TW_W-1:0] word_d;

  always_comb begin
    word_d = (word_q & ~wr_mask) | (wr_data & wr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_en) begin
      word_q <= word_d;
    end
  end

  assign word = word_q;

endmodule

// File: rtl/ata_tword_bank.sv
module ata_tword_bank
  import ata_strobe_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int DEV_W   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [DEV_W-1:0] upd_dev,
  input  logic [1:0]       upd_class,
  input  logic [TW_W-1:0]  upd_word,
  input  logic [DEV_W-1:0] rsel_a,
  output logic [TW_W-1:0]  rdata_a,
  input  logic [DEV_W-1:0] rsel_b,
  output logic [TW_W-1:0]  rdata_b
);

  logic [TW_W-1:0] words [NUM_DEV];
  logic [TW_W-1:0] upd_mask;
  logic            upd_any;

  assign upd_mask = class_mask(upd_class);
  assign upd_any  = upd_valid && (upd_class != CLS_NONE);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic dev_hit;
    assign dev_hit = upd_any && (upd_dev == DEV_W'(g));
    ata_tword_reg u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dev_hit),
      .wr_mask (upd_mask),
      .wr_data (upd_word),
      .word    (words[g])
    );
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (rsel_a == DEV_W'(i)) rdata_a = words[i];
      if (rsel_b == DEV_W'(i)) rdata_b = words[i];
    end
  end

endmodule

// File: rtl/ata_phase_counter.sv
module ata_phase_counter
  import ata_strobe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ata_strobe_seq.sv
module ata_strobe_seq
  import ata_strobe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_tf,
  input  logic             req_wr,
  input  logic             req_first,
  input  logic [TW_W-1:0]  tword,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             ready,
  output logic             rd_n,
  output logic             wr_n,
  output logic             done
);

  phase_e           phase_q, phase_d;
  logic [ACT_W-1:0] act_q, act_d;
  logic [REC_W-1:0] rec_q, rec_d;
  logic             wr_q, wr_d;
  logic             done_q, done_d;
  logic             rd_n_q, rd_n_d;
  logic             wr_n_q, wr_n_d;
  acc_timing_t      tm;

  assign tm = pick_timing(tword, req_tf);

  always_comb begin
    phase_d  = phase_q;
    act_d    = act_q;
    rec_d    = rec_q;
    wr_d     = wr_q;
    done_d   = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          act_d    = tm.act;
          rec_d    = tm.rec;
          wr_d     = req_wr;
          cnt_load = 1'b1;
          if (req_first && (tm.setup != '0)) begin
            phase_d = PH_SETUP;
            cnt_val = CNT_W'(tm.setup) - CNT_W'(1);
          end else begin
            phase_d = PH_ACTIVE;
            cnt_val = tm.act;
          end
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d  = PH_ACTIVE;
          cnt_load = 1'b1;
          cnt_val  = act_q;
        end
      end
      PH_ACTIVE: begin
        if (cnt_zero) begin
          phase_d  = PH_RECOV;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(rec_q);
        end
      end
      PH_RECOV: begin
        if (cnt_zero) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    rd_n_d = !((phase_d == PH_ACTIVE) && !wr_d);
    wr_n_d = !((phase_d == PH_ACTIVE) && wr_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      act_q   <= '0;
      rec_q   <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      rd_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
      rd_n_q  <= rd_n_d;
      wr_n_q  <= wr_n_d;
      if (cnt_load && (phase_q == PH_IDLE)) begin
        act_q <= act_d;
        rec_q <= rec_d;
        wr_q  <= wr_d;
      end
    end
  end

  assign ready = (phase_q == PH_IDLE);
  assign rd_n  = rd_n_q;
  assign wr_n  = wr_n_q;
  assign done  = done_q;

endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
  import ata_strobe_pkg::*;
#(
  parameter int  NUM_DEV = 2,
  localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [DEV_W-1:0] upd_dev,
  input  logic [1:0]       upd_class,
  input  logic [31:0]      upd_word,
  input  logic [DEV_W-1:0] tw_rsel,
  output logic [31:0]      tw_rdata,
  input  logic             req_valid,
  input  logic [DEV_W-1:0] req_dev,
  input  logic             req_taskfile,
  input  logic             req_write,
  input  logic             req_first,
  output logic             req_ready,
  output logic             rd_strobe_n,
  output logic             wr_strobe_n,
  output logic             xfer_done
);

  logic [TW_W-1:0]  req_word;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;

  ata_tword_bank #(
    .NUM_DEV (NUM_DEV),
    .DEV_W   (DEV_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_dev   (upd_dev),
    .upd_class (upd_class),
    .upd_word  (upd_word),
    .rsel_a    (req_dev),
    .rdata_a   (req_word),
    .rsel_b    (tw_rsel),
    .rdata_b   (tw_rdata)
  );

  ata_phase_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  ata_strobe_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (req_valid),
    .req_tf    (req_taskfile),
    .req_wr    (req_write),
    .req_first (req_first),
    .tword     (req_word),
    .cnt_zero  (cnt_zero),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .ready     (req_ready),
    .rd_n      (rd_strobe_n),
    .wr_n      (wr_strobe_n),
    .done      (xfer_done)
  );

endmodule

// File: rtl/ata_strobe_timer_chk.sv
module ata_strobe_timer_chk #(
  parameter int DEV_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_valid,
  input logic [DEV_W-1:0] tw_rsel,
  input logic [31:0]      tw_rdata,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rd_strobe_n,
  input logic             wr_strobe_n,
  input logic             xfer_done
);

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_strobe_n && !wr_strobe_n)); // R6

  AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rd_strobe_n && wr_strobe_n)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R7

  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> req_ready); // R7

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8

  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(upd_valid) && $stable(tw_rsel)) |-> $stable(tw_rdata)); // R9

endmodule

bind ata_strobe_timer ata_strobe_timer_chk #(.DEV_W(DEV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd_valid   (upd_valid),
  .tw_rsel     (tw_rsel),
  .tw_rdata    (tw_rdata),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rd_strobe_n (rd_strobe_n),
  .wr_strobe_n (wr_strobe_n),
  .xfer_done   (xfer_done)
);

// File: tb/ata_strobe_timer_tb.sv
module ata_strobe_timer_tb;

  logic        clk;
  logic        rst_n;
  logic        upd_valid;
  logic [0:0]  upd_dev;
  logic [1:0]  upd_class;
  logic [31:0] upd_word;
  logic [0:0]  tw_rsel;
  logic [31:0] tw_rdata;
  logic        req_valid;
  logic [0:0]  req_dev;
  logic        req_taskfile;
  logic        req_write;
  logic        req_first;
  logic        req_ready;
  logic        rd_strobe_n;
  logic        wr_strobe_n;
  logic        xfer_done;

  int errors = 0;
  int checks = 0;
  logic [31:0] shadow [2];

  ata_strobe_timer #(.NUM_DEV(2)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_valid    (upd_valid),
    .upd_dev      (upd_dev),
    .upd_class    (upd_class),
    .upd_word     (upd_word),
    .tw_rsel      (tw_rsel),
    .tw_rdata     (tw_rdata),
    .req_valid    (req_valid),
    .req_dev      (req_dev),
    .req_taskfile (req_taskfile),
    .req_write    (req_write),
    .req_first    (req_first),
    .req_ready    (req_ready),
    .rd_strobe_n  (rd_strobe_n),
    .wr_strobe_n  (wr_strobe_n),
    .xfer_done    (xfer_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [0:0]  dev;
    logic [1:0]  cls;
    logic [31:0] word;
    logic        tf;
    logic        wr;
    logic        first;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 2'd0, 32'h0080_0031, 1'b0, 1'b0, 1'b1},
    '{1'b0, 2'd0, 32'h0200_8400, 1'b1, 1'b1, 1'b1},
    '{1'b1, 2'd1, 32'h0040_0052, 1'b0, 1'b0, 1'b1},
    '{1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0},
    '{1'b0, 2'd0, 32'h0FC3_FFFF, 1'b0, 1'b1, 1'b1},
    '{1'b0, 2'd3, 32'h0000_0000, 1'b1, 1'b0, 1'b0},
    '{1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1},
    '{1'b0, 2'd1, 32'h0000_0000, 1'b0, 1'b0, 1'b1}
  };

  function automatic logic [31:0] spec_mask(input logic [1:0] cls);
    case (cls)
      2'd0:    return 32'hCFC3_FFFF;
      2'd1:    return 32'h31C0_01FF;
      2'd2:    return 32'h303C_0000;
      default: return 32'h0000_0000;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_update(input logic [0:0] dev, input logic [1:0] cls,
                           input logic [31:0] w);
    @(negedge clk);
    upd_valid = 1'b1; upd_dev = dev; upd_class = cls; upd_word = w;
    @(negedge clk);
    upd_valid = 1'b0;
    shadow[dev] = (shadow[dev] & ~spec_mask(cls)) | (w & spec_mask(cls));
    tw_rsel = dev;
    #1;
    chk(tw_rdata == shadow[dev], "R9", tw_rdata, shadow[dev]);
  endtask

  // Run one access and measure it; optional mid-access update and busy poke.
  task automatic run_access(input logic [0:0] dev, input logic tf,
                            input logic wr, input logic first,
                            input string tag, input int upd_at,
                            input logic [31:0] upd_w, input logic poke);
    int s, a, r;
    int lo_cnt, other_cnt, first_lo, done_idx, ready_bad;
    logic [31:0] w;
    w = shadow[dev];
    if (tf) begin s = int'(w[27:25]); a = int'(w[17:13]); r = int'(w[12:9]); end
    else    begin s = int'(w[24:22]); a = int'(w[8:4]);   r = int'(w[3:0]);  end
    if (!first) s = 0;
    lo_cnt = 0; other_cnt = 0; first_lo = 0; done_idx = 0; ready_bad = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_dev = dev; req_taskfile = tf;
    req_write = wr; req_first = first;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (i == 1) req_valid = 1'b0;
      if (upd_at != 0 && i == upd_at) begin
        upd_valid = 1'b1; upd_dev = dev; upd_class = 2'd0; upd_word = upd_w;
      end
      if (upd_at != 0 && i == upd_at + 1) begin
        upd_valid = 1'b0;
        shadow[dev] = (shadow[dev] & ~spec_mask(2'd0)) | (upd_w & spec_mask(2'd0));
      end
      if (poke && i == 2) begin
        req_valid = 1'b1; req_taskfile = ~tf; req_write = ~wr; req_first = 1'b1;
      end
      if (poke && i == 3) req_valid = 1'b0;
      if ((wr ? wr_strobe_n : rd_strobe_n) == 1'b0) begin
        lo_cnt++;
        if (first_lo == 0) first_lo = i;
      end
      if ((wr ? rd_strobe_n : wr_strobe_n) == 1'b0) other_cnt++;
      if (xfer_done) begin
        done_idx = i;
        break;
      end
      if (req_ready) ready_bad++;
    end
    chk(lo_cnt == a + 1, tag, 32'(lo_cnt), 32'(a + 1));
    chk(other_cnt == 0, "R6", 32'(other_cnt), 32'd0);
    chk(first_lo == s + 1, first ? "R4" : "R5", 32'(first_lo), 32'(s + 1));
    chk(done_idx == s + a + r + 3, "R7", 32'(done_idx), 32'(s + a + r + 3));
    chk(ready_bad == 0, "R8", 32'(ready_bad), 32'd0);
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(rd_strobe_n && wr_strobe_n && req_ready && !xfer_done, "R8",
            {29'd0, rd_strobe_n, wr_strobe_n, req_ready}, 32'd7);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    upd_valid = 1'b0; upd_dev = '0; upd_class = 2'd0; upd_word = '0;
    tw_rsel = '0;
    req_valid = 1'b0; req_dev = '0; req_taskfile = 1'b0;
    req_write = 1'b0; req_first = 1'b0;
    shadow[0] = '0; shadow[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: during reset
    chk(rd_strobe_n && wr_strobe_n, "R1", {30'd0, rd_strobe_n, wr_strobe_n}, 32'd3);
    chk(req_ready && !xfer_done, "R1", {30'd0, req_ready, xfer_done}, 32'd2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_strobe_n && wr_strobe_n && req_ready && !xfer_done, "R1",
        {28'd0, rd_strobe_n, wr_strobe_n, req_ready, xfer_done}, 32'he);
    for (int d = 0; d < 2; d++) begin
      tw_rsel = d[0:0];
      #1;
      chk(tw_rdata == 32'd0, "R1", tw_rdata, 32'd0);
    end

    // Vector table: update then access, expectations from the shadow word.
    for (int k = 0; k < NVEC; k++) begin
      do_update(VEC[k].dev, VEC[k].cls, VEC[k].word);
      run_access(VEC[k].dev, VEC[k].tf, VEC[k].wr, VEC[k].first,
                 VEC[k].tf ? "R3" : "R2", 0, 32'd0, 1'b0);
    end

    // R9: class 3 leaves the word unchanged; UDMA class stores only its bits.
    do_update(1'b0, 2'd0, 32'h0000_0000);
    do_update(1'b0, 2'd3, 32'hFFFF_FFFF);
    do_update(1'b0, 2'd2, 32'hFFFF_FFFF);
    chk(tw_rdata == 32'h303C_0000, "R9", tw_rdata, 32'h303C_0000);
    run_access(1'b0, 1'b0, 1'b1, 1'b1, "R9", 0, 32'd0, 1'b0);

    // R10: update during an access does not alter it; next access uses it.
    do_update(1'b0, 2'd0, 32'h0000_0042);
    run_access(1'b0, 1'b0, 1'b0, 1'b0, "R10", 2, 32'h0000_0010, 1'b0);
    chk(shadow[0][8:0] == 9'h010, "R10", shadow[0], 32'h0000_0010);
    run_access(1'b0, 1'b0, 1'b0, 1'b0, "R10", 0, 32'd0, 1'b0);

    // R8: request while busy is ignored.
    do_update(1'b0, 2'd0, 32'h0000_0000);
    run_access(1'b0, 1'b0, 1'b0, 1'b1, "R2", 0, 32'd0, 1'b1);
    do_update(1'b0, 2'd0, 32'h0000_0033);
    run_access(1'b0, 1'b1, 1'b1, 1'b1, "R3", 0, 32'd0, 1'b1);

    // R11: each device uses its own word.
    do_update(1'b0, 2'd0, 32'h0000_0011);
    do_update(1'b1, 2'd0, 32'h0000_0063);
    run_access(1'b1, 1'b0, 1'b0, 1'b1, "R11", 0, 32'd0, 1'b0);
    run_access(1'b0, 1'b0, 1'b0, 1'b1, "R11", 0, 32'd0, 1'b0);

    // R5: continuing cycles skip a large setup field, back to back.
    do_update(1'b1, 2'd0, 32'h0FC0_0021);
    run_access(1'b1, 1'b0, 1'b1, 1'b0, "R2", 0, 32'd0, 1'b0);
    run_access(1'b1, 1'b1, 1'b0, 1'b0, "R3", 0, 32'd0, 1'b0);
    run_access(1'b1, 1'b1, 1'b0, 1'b1, "R4", 0, 32'd0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule